// File: doc/BRIEF.md
# Parallel Bus Write Cycle Qualifier

This block sits at the pin side of a parallel flash-style bus slave. Three active-low strobes (select, write strobe, output enable), an address bus, a data bus and a low-supply lockout flag arrive with no relation to the block clock. A fast sample clock brings every strobe through a two-flop synchronizer and then through a debounce stage. A level change is taken only after it has held for `GLITCH_CYC` consecutive samples, whether the strobe falls or rises. The address and data buses pass through a delay line of matching depth, so that a value captured at a strobe edge is the value that was on the bus when that edge was sampled.

A write window is open while select and write strobe are both low and output enable is high. The address is taken when the window opens, which is at the later of the two falling strobes. The data is taken when the window closes at the earlier rising strobe, and a one-cycle write pulse then carries both to the command logic downstream. Writes are refused until the window has been seen closed once after reset, and also during lockout. During lockout a reset-to-read request is raised. A separate read-enable output is asserted whenever select and output enable are both low.

Top module: `bus_write_qualifier`

## Requirements
- R1: A write window exists only while the debounced select and write strobe are both 0 and the debounced output enable is 1. If output enable goes 0 while a window is open, the window ends and no write pulse is produced.
- R2: `wr_addr` carries the `addr_in` value that was present at the sample clock edge where the later of select and write strobe was seen low.
- R3: When a window ends because select or write strobe rises, `wr_valid` is 1 for exactly one cycle. It carries the `data_in` value present at the sample edge where that rise was seen. A strobe change sampled at clock edge k gives `wr_valid` = 1 in the cycle after edge k+GLITCH_CYC+2.
- R4: A strobe low pulse that lasts fewer than `GLITCH_CYC` consecutive samples produces no write.
- R5: A strobe high pulse inside an open window that lasts fewer than `GLITCH_CYC` samples does not end the window. Exactly one write is produced at the real end of the window.
- R6: If select and write strobe are already low (with output enable high) when reset is released, the first rising strobe produces no write. Writes are accepted only after the window has been seen closed.
- R7: While `lockout` is 1, no write pulse is produced and any open window is discarded. `rst_to_read` follows `lockout` two clocks later. After release, a window that was already open when lockout ended produces no write.
- R8: `rd_en` is 1 exactly when the debounced select and output enable are both 0.
- R9: After reset, `wr_valid`, `rst_to_read` and `rd_en` are 0, and `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select strobe, asynchronous |
| wstb_n | input | 1 | Active-low write strobe, asynchronous |
| oen_n | input | 1 | Active-low output enable, asynchronous |
| lockout | input | 1 | Low-supply lockout flag, asynchronous |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| wr_valid | output | 1 | One-cycle qualified write pulse |
| wr_addr | output | AW | Address latched at window open |
| wr_data | output | DW | Data latched at window close |
| rd_en | output | 1 | Drive enable for the read data bus |
| rst_to_read | output | 1 | Reset-to-read request during lockout |

## Verification
The bench changes the address after the window has opened and the data after it has closed. A design that takes the address at the wrong edge, or that loses the alignment of the delay line, reports the later value. Low pulses and high blips one sample shorter than the threshold are applied: a debounce that covers only one direction would issue a spurious write or split one window into two. Power-up with both strobes low, lockout that arrives in the middle of a window, and output enable falling inside a window are each applied. A design without the arming rule, or one that ignores lockout, would issue writes that the reference model does not expect.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
    localparam int unsigned STB_SEL  = 0;
    localparam int unsigned STB_WSTB = 1;
    localparam int unsigned STB_OEN  = 2;
    localparam int unsigned STB_LOCK = 3;
    localparam int unsigned N_FILT   = 3;
    localparam int unsigned N_SYNC   = 4;
    // idle levels: strobes high, lockout low
    localparam logic [N_SYNC-1:0] SYNC_IDLE = 4'b0111;
endpackage

// File: rtl/wrq_sync.sv
module wrq_sync #(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] m1;
        logic [W-1:0] m2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.m1 = async_in;
        st_d.m2 = st_q.m1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{m1: IDLE, m2: IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.m2;
endmodule

// File: rtl/wrq_deglitch.sv
module wrq_deglitch #(
    parameter int unsigned HOLD = 3,
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);
    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] run;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level_in != st_q.lvl) begin
            if (st_q.run == LAST) begin
                st_d.lvl = level_in;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: IDLE, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_out = st_q.lvl;
endmodule

// File: rtl/wrq_delay.sv
module wrq_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [DEPTH];
    logic [W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb stage_d[g] = din;
        end else begin : g_body
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/bus_write_qualifier.sv
module bus_write_qualifier
    import wrq_pkg::*;
#(
    parameter int unsigned AW         = 15,
    parameter int unsigned DW         = 8,
    parameter int unsigned GLITCH_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wstb_n,
    input  logic          oen_n,
    input  logic          lockout,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic          rst_to_read
);
    // bus delay equals synchronizer plus debounce latency
    localparam int unsigned PIPE_D = GLITCH_CYC + 2;
    localparam int unsigned SETTLE = GLITCH_CYC + 3;
    localparam int unsigned SW     = $clog2(SETTLE + 1);
    localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

    typedef struct packed {
        logic [SW-1:0] settle;
        logic          armed;
        logic          win_prev;
        logic          in_win;
        logic [AW-1:0] addr_lat;
        logic          wv;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
    } st_t;

    st_t st_d, st_q;

    logic [N_SYNC-1:0] raw_vec;
    logic [N_SYNC-1:0] syn_vec;
    logic [N_FILT-1:0] flt_vec;
    logic [AW-1:0]     addr_dly;
    logic [DW-1:0]     data_dly;
    logic              win_now;
    logic              lock_s;
    logic              settled;
    logic              open_ev;
    logic              close_ev;

    assign raw_vec = {lockout, oen_n, wstb_n, sel_n};

    wrq_sync #(.W(N_SYNC), .IDLE(SYNC_IDLE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_vec),
        .sync_out (syn_vec)
    );

    for (genvar s = 0; s < N_FILT; s++) begin : g_filt
        wrq_deglitch #(.HOLD(GLITCH_CYC), .IDLE(1'b1)) u_dg (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_in  (syn_vec[s]),
            .level_out (flt_vec[s])
        );
    end

    wrq_delay #(.W(AW), .DEPTH(PIPE_D)) u_adly (
        .clk (clk), .rst_n (rst_n), .din (addr_in), .dout (addr_dly)
    );

    wrq_delay #(.W(DW), .DEPTH(PIPE_D)) u_ddly (
        .clk (clk), .rst_n (rst_n), .din (data_in), .dout (data_dly)
    );

    assign win_now  = !flt_vec[STB_SEL] && !flt_vec[STB_WSTB] && flt_vec[STB_OEN];
    assign lock_s   = syn_vec[STB_LOCK];
    assign settled  = (st_q.settle == SETTLE_V);
    assign open_ev  = win_now && !st_q.win_prev && st_q.armed && !lock_s;
    assign close_ev = st_q.in_win && !win_now && !lock_s;

    always_comb begin
        st_d          = st_q;
        st_d.wv       = 1'b0;
        st_d.win_prev = win_now;

        if (!settled) begin
            st_d.settle = st_q.settle + 1'b1;
        end

        if (lock_s) begin
            st_d.armed = 1'b0;
        end else if (settled && !win_now) begin
            st_d.armed = 1'b1;
        end

        if (open_ev) begin
            st_d.addr_lat = addr_dly;
            st_d.in_win   = 1'b1;
        end

        if (close_ev) begin
            st_d.in_win = 1'b0;
            // output enable still high: window ended by a rising strobe
            if (flt_vec[STB_OEN]) begin
                st_d.wv = 1'b1;
                st_d.wa = st_q.addr_lat;
                st_d.wd = data_dly;
            end
        end

        if (lock_s) begin
            st_d.in_win = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid    = st_q.wv;
    assign wr_addr     = st_q.wa;
    assign wr_data     = st_q.wd;
    assign rd_en       = !flt_vec[STB_SEL] && !flt_vec[STB_OEN];
    assign rst_to_read = lock_s;
endmodule

// File: rtl/wrq_checker.sv
module wrq_checker #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic          rst_to_read
);
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_to_read |=> !wr_valid);

    p_read_blocks_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !wr_valid);

    p_hold_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

bind bus_write_qualifier wrq_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rst_to_read (rst_to_read)
);

// File: tb/bus_write_qualifier_tb_top.sv
module bus_write_qualifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int G  = 3;
    localparam int D  = G + 2;
    localparam int SETTLE = G + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b0, wstb_n = 1'b0, oen_n = 1'b1, lockout = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic wr_valid, rd_en, rst_to_read;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int vectors = 0;
    int miscompares = 0;
    int wr_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_write_qualifier #(.AW(AW), .DW(DW), .GLITCH_CYC(G)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .oen_n(oen_n),
        .lockout(lockout), .addr_in(addr_in), .data_in(data_in),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rst_to_read(rst_to_read)
    );

    // behavioural reference model, state after each rising edge
    bit m_a[4], m_b[4];
    bit m_lvl[3];
    int m_run[3];
    int m_settle;
    bit m_armed, m_prev, m_open, m_wv;
    int m_alat, m_wa, m_wd;
    int aq[$];
    int dq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a = '{1, 1, 1, 0}; m_b = '{1, 1, 1, 0};
            m_lvl = '{1, 1, 1}; m_run = '{0, 0, 0};
            m_settle = 0; m_armed = 0; m_prev = 0; m_open = 0; m_wv = 0;
            m_alat = 0; m_wa = 0; m_wd = 0;
            aq.delete(); dq.delete();
            for (int i = 0; i < D; i++) begin aq.push_back(0); dq.push_back(0); end
        end else begin
            bit win, lk, op, cl, oe_hi;
            int a_old, d_old;
            win   = !m_lvl[0] && !m_lvl[1] && m_lvl[2];
            oe_hi = m_lvl[2];
            lk    = m_b[3];
            a_old = aq[0]; d_old = dq[0];
            op = win && !m_prev && m_armed && !lk;
            cl = m_open && !win && !lk;
            m_wv = cl && oe_hi;
            if (m_wv) begin m_wa = m_alat; m_wd = d_old; end
            if (op) begin m_alat = a_old; m_open = 1; end
            if (cl || lk) m_open = 0;
            if (lk) m_armed = 0;
            else if (m_settle == SETTLE && !win) m_armed = 1;
            m_prev = win;
            if (m_settle < SETTLE) m_settle++;
            for (int i = 0; i < 3; i++) begin
                if (m_b[i] != m_lvl[i]) begin
                    if (m_run[i] == G - 1) begin m_lvl[i] = m_b[i]; m_run[i] = 0; end
                    else m_run[i]++;
                end else m_run[i] = 0;
            end
            m_b = m_a;
            m_a = '{sel_n, wstb_n, oen_n, lockout};
            void'(aq.pop_front()); aq.push_back(int'(addr_in));
            void'(dq.pop_front()); dq.push_back(int'(data_in));
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 wr_valid", int'(wr_valid), int'(m_wv));
            chk("R2 wr_addr", int'(wr_addr), m_wa);
            chk("R3 wr_data", int'(wr_data), m_wd);
            chk("R8 rd_en", int'(rd_en), int'(!m_lvl[0] && !m_lvl[2]));
            chk("R7 rst_to_read", int'(rst_to_read), int'(m_b[3]));
            if (wr_valid) wr_seen++;
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobes(input logic s, input logic w, input logic o);
        sel_n = s; wstb_n = w; oen_n = o;
    endtask

    task automatic count_is(input string tag, input int base, input int exp);
        chk(tag, wr_seen - base, exp);
    endtask

    initial begin
        int base;
        // R6: power-up with select and write strobe already low
        hold(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset wr_valid", int'(wr_valid), 0);
        chk("R9 reset wr_addr", int'(wr_addr), 0);
        chk("R9 reset rst_to_read", int'(rst_to_read), 0);
        chk("R9 reset rd_en", int'(rd_en), 0);
        base = wr_seen;
        addr_in = 15'h0123; data_in = 8'h11;
        hold(12);
        wstb_n = 1'b1;
        hold(12);
        sel_n = 1'b1;
        hold(10);
        count_is("R6 power-up rise ignored", base, 0);

        // R2/R3: write-strobe controlled cycle
        base = wr_seen;
        addr_in = 15'h1A5A; sel_n = 1'b0; hold(4);
        wstb_n = 1'b0; hold(2);
        addr_in = 15'h7FFF; data_in = 8'h3C; hold(6);
        wstb_n = 1'b1; hold(1);
        data_in = 8'hEE; hold(3);
        sel_n = 1'b1; hold(12);
        count_is("R3 one write", base, 1);
        chk("R2 address at later fall", int'(wr_addr), 15'h1A5A);
        chk("R3 data at earlier rise", int'(wr_data), 8'h3C);

        // R2/R3: select controlled cycle
        base = wr_seen;
        wstb_n = 1'b0; addr_in = 15'h0042; hold(5);
        addr_in = 15'h2222; sel_n = 1'b0; hold(2);
        addr_in = 15'h0001; data_in = 8'hA5; hold(5);
        sel_n = 1'b1; hold(1);
        data_in = 8'h00; hold(2);
        wstb_n = 1'b1; hold(12);
        count_is("R3 select-controlled write", base, 1);
        chk("R2 select-controlled address", int'(wr_addr), 15'h2222);
        chk("R3 select-controlled data", int'(wr_data), 8'hA5);

        // R4: short low pulse
        base = wr_seen;
        sel_n = 1'b0; hold(3);
        wstb_n = 1'b0; hold(G - 1);
        wstb_n = 1'b1; hold(12);
        sel_n = 1'b1; hold(8);
        count_is("R4 short low pulse", base, 0);

        // R5: short high blip inside a window
        base = wr_seen;
        sel_n = 1'b0; wstb_n = 1'b0; addr_in = 15'h0555; data_in = 8'h5A; hold(8);
        wstb_n = 1'b1; hold(G - 1);
        wstb_n = 1'b0; hold(8);
        wstb_n = 1'b1; hold(3);
        sel_n = 1'b1; hold(12);
        count_is("R5 blip keeps window", base, 1);

        // R1: output enable low in a window, plus read enable
        base = wr_seen;
        sel_n = 1'b0; wstb_n = 1'b0; hold(8);
        oen_n = 1'b0; hold(8);
        wstb_n = 1'b1; hold(8);
        chk("R8 rd_en with select and oe low", int'(rd_en), 1);
        oen_n = 1'b1; sel_n = 1'b1; hold(10);
        count_is("R1 oe low inhibits", base, 0);
        chk("R8 rd_en released", int'(rd_en), 0);

        // R7: lockout in the middle of a window
        base = wr_seen;
        sel_n = 1'b0; wstb_n = 1'b0; hold(8);
        lockout = 1'b1; hold(4);
        chk("R7 rst_to_read raised", int'(rst_to_read), 1);
        wstb_n = 1'b1; hold(6);
        wstb_n = 1'b0; hold(8);
        lockout = 1'b0; hold(8);
        wstb_n = 1'b1; hold(8);
        sel_n = 1'b1; hold(10);
        count_is("R7 lockout blocks writes", base, 0);

        // R7: normal write after lockout released
        base = wr_seen;
        strobes(1'b0, 1'b0, 1'b1); addr_in = 15'h4321; data_in = 8'h81; hold(8);
        strobes(1'b1, 1'b1, 1'b1); hold(12);
        count_is("R7 write after release", base, 1);
        chk("R7 payload after release", int'(wr_data), 8'h81);

        hold(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule